// File: doc/BRIEF.md
# HDLC Transmit Packer with 56k Line Mode

This block turns one B-channel's payload bytes into the raw HDLC line bit stream, packed into octets. Each frame starts with a 0x7E flag. The payload follows, with a CRC-16 running over it. Next comes the complemented frame check sequence, and a 0x7E flag closes the frame. A zero bit is inserted after any run of five ones, but only inside the payload and the check sequence.

Two line rates are supported. In 64 kbit/s packing every output octet carries 8 line bits. In 56 kbit/s packing every output octet carries 7 line bits in bits 6..0, and bit 7 is always one.

Payload bytes arrive on a valid/ready stream with a last marker. Octets leave on a valid/ready stream. The packing mode is captured when a frame starts.

Top module: `hdlc_tx_packer`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are both low, and they stay low until a payload byte is offered.
- R2: A frame begins with the flag bits 0x7E. In 64k mode the first octet of every frame is therefore 0x7E.
- R3: Line bits go out least significant bit first. Each new bit enters at bit 7 of an octet that shifts right, so the first line bit of an 8-bit octet ends up in bit 0.
- R4: A zero is inserted after five consecutive ones in the payload or the check sequence. Every zero resets the run count, including an inserted zero. The flags are never stuffed.
- R5: The check sequence is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF. It covers the payload bytes, is complemented, and is sent low byte first, then high byte.
- R6: In 56k mode an octet is produced after every 7 line bits. The 7 bits sit in bits 6..0, first bit in bit 0, and bit 7 is 1. A 56k frame therefore opens with the octet 0xFE.
- R7: If the closing flag leaves a partial octet, the unused upper positions are filled with ones and that octet is sent, followed by one extra 0xFF octet. A frame whose closing flag ends exactly on an octet boundary has neither.
- R8: `in_ready` is low whenever an output octet is waiting (`out_valid` high) or an inserted zero is still to be sent.
- R9: `mode_56k` is sampled when a frame starts. Changing it during the frame has no effect on that frame.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R11: A byte offered straight after a last byte is held back until the previous frame's closing flag and any padding have been produced. It then starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_56k | input | 1 | 1 selects 7-bit packing, 0 selects 8-bit packing; sampled at frame start |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte of a frame |
| in_ready | output | 1 | Payload byte accepted when high together with in_valid |
| out_valid | output | 1 | Line octet available |
| out_data | output | 8 | Packed line octet |
| out_ready | input | 1 | Downstream takes the octet |

## Verification
The bit position counter, the ones-run counter and the octet fill counter all affect the packed octets at the ports. A single wrong value in any of them shifts or corrupts every later bit of the frame. Such an error shows up in the first octet that completes after it, and it also changes the octet count and the padding decision at the frame's end. A wrong CRC state shows up only in the two check-sequence octets and the ones that follow them. So every frame is compared octet by octet against a bit-level model, and its total length is checked, both with and without back-pressure.

// File: rtl/hdlc_tx_packer.sv
module hdlc_tx_packer #(
  parameter logic [7:0]  FLAG      = 8'h7E,
  parameter logic [15:0] CRC_POLY  = 16'h8408,
  parameter int          STUFF_RUN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_56k,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [OW-1:0] RUN = OW'(STUFF_RUN);

  typedef enum logic [3:0] {
    P_IDLE, P_OPEN, P_FETCH, P_DATA, P_FCSL, P_FCSH, P_CLOSE, P_PAD, P_XFF
  } phase_t;

  phase_t        ph;
  logic          m56, stuff_pend, last_b;
  logic [2:0]    bi;
  logic [3:0]    cnt;
  logic [OW-1:0] ones;
  logic [7:0]    sh, acc;
  logic [15:0]   crc;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 8; k++)
      r = (r[0] ^ d[k]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  wire adv  = !out_valid || out_ready;
  assign in_ready = (ph == P_FETCH) && !stuff_pend && !out_valid;
  wire take = in_valid && in_ready;
  wire [15:0] fcs = ~crc;

  logic bit_en, lb;
  always_comb begin
    bit_en = 1'b0;
    lb     = 1'b1;
    if (stuff_pend) begin
      bit_en = 1'b1;
      lb     = 1'b0;
    end else begin
      case (ph)
        P_OPEN, P_CLOSE:        begin bit_en = 1'b1; lb = FLAG[bi]; end
        P_DATA, P_FCSL, P_FCSH: begin bit_en = 1'b1; lb = sh[bi];   end
        P_PAD:                  bit_en = 1'b1;
        default: ;
      endcase
    end
  end

  wire [7:0]    acc_n    = {lb, acc[7:1]};
  wire [3:0]    cnt_n    = cnt + 4'd1;
  wire          padding  = (ph == P_PAD) && !stuff_pend;
  wire          full     = bit_en && (padding ? (cnt_n == 4'd8) : (cnt_n == (m56 ? 4'd7 : 4'd8)));
  wire [7:0]    oct      = (m56 && !padding) ? {1'b1, acc_n[7:1]} : acc_n;
  wire [OW-1:0] ones_n   = ones + 1'b1;
  wire          run_hit  = lb && (ones_n == RUN);
  wire          byte_end = (bi == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_IDLE; m56 <= 1'b0; stuff_pend <= 1'b0; last_b <= 1'b0;
      bi <= '0; cnt <= '0; ones <= '0; sh <= '0; acc <= '0; crc <= '1;
      out_valid <= 1'b0; out_data <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (adv) begin
        if (bit_en) begin
          acc <= acc_n;
          cnt <= full ? 4'd0 : cnt_n;
          if (full) begin
            out_valid <= 1'b1;
            out_data  <= oct;
          end
        end
        if (stuff_pend) begin
          stuff_pend <= 1'b0;
          ones       <= '0;
        end else begin
          case (ph)
            P_IDLE: if (in_valid) begin
              ph <= P_OPEN; m56 <= mode_56k; bi <= '0; cnt <= '0;
              ones <= '0; crc <= '1;
            end
            P_OPEN: begin
              bi <= bi + 3'd1;
              if (byte_end) ph <= P_FETCH;
            end
            P_FETCH: if (take) begin
              sh <= in_data; last_b <= in_last;
              crc <= crc_step(crc, in_data);
              bi <= '0; ph <= P_DATA;
            end
            P_DATA, P_FCSL, P_FCSH: begin
              if (run_hit) begin
                stuff_pend <= 1'b1;
                ones       <= '0;
              end else if (lb) ones <= ones_n;
              else ones <= '0;
              bi <= bi + 3'd1;
              if (byte_end) begin
                case (ph)
                  P_DATA: if (last_b) begin
                    ph <= P_FCSL; sh <= fcs[7:0];
                  end else ph <= P_FETCH;
                  P_FCSL: begin ph <= P_FCSH; sh <= fcs[15:8]; end
                  default: ph <= P_CLOSE;
                endcase
              end
            end
            P_CLOSE: begin
              bi <= bi + 3'd1;
              if (byte_end) ph <= full ? P_IDLE : P_PAD;
            end
            P_PAD: if (full) ph <= P_XFF;
            P_XFF: begin
              out_valid <= 1'b1;
              out_data  <= 8'hFF;
              ph        <= P_IDLE;
            end
            default: ph <= P_IDLE;
          endcase
        end
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
  AST_TOP_BIT_56K: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && m56 && ph != P_IDLE && ph != P_OPEN |-> out_data[7]); // R6
  AST_RUN_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ones < RUN); // R4
  AST_SINGLE_STUFF: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_pend && adv |=> !stuff_pend); // R4
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ph != P_IDLE && $past(ph) != P_IDLE |-> $stable(m56)); // R9
endmodule

// File: tb/hdlc_tx_packer_tb.sv
`timescale 1ns/1ps
module hdlc_tx_packer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic mode_56k = 1'b0, in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid;
  logic [7:0] out_data;

  hdlc_tx_packer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_56k(mode_56k),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  // {mode[24], len[23:16], first[15:8], step[7:0]}
  localparam logic [31:0] VEC [8] = '{
    32'h0001_5500, 32'h0004_FF00, 32'h0006_0113, 32'h0103_7E00,
    32'h0105_FF00, 32'h0108_1021, 32'h0010_0011, 32'h0102_0000
  };
  localparam string VTAG [8] = '{"R3", "R4", "R5", "R6", "R4", "R5", "R7", "R7"};

  int n_chk = 0, n_fail = 0;
  logic [7:0] sb [0:255];
  logic       sl [0:255];
  logic [7:0] eb [0:1023];
  logic [7:0] rb [0:1023];
  int s_n, e_n, r_n, bad_ready;
  logic [7:0] e_acc;
  int e_cnt, e_ones;
  logic e_m56;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    e_acc = {b, e_acc[7:1]};
    e_cnt++;
    if (e_cnt == (e_m56 ? 7 : 8)) begin
      eb[e_n] = e_m56 ? {1'b1, e_acc[7:1]} : e_acc;
      e_n++;
      e_cnt = 0;
    end
  endtask

  task automatic data_bit(input logic b);
    put_bit(b);
    if (b) begin
      e_ones++;
      if (e_ones == 5) begin put_bit(1'b0); e_ones = 0; end
    end else e_ones = 0;
  endtask

  task automatic model_frame(input logic m, input int len, input logic [7:0] first, input logic [7:0] step);
    logic [15:0] c;
    logic [7:0] b;
    c = 16'hFFFF; e_m56 = m; e_ones = 0; e_cnt = 0;
    for (int j = 0; j < 8; j++) put_bit(8'h7E >> j);
    for (int i = 0; i < len; i++) begin
      b = first + 8'(i * step);
      sb[s_n] = b; sl[s_n] = (i == len - 1); s_n++;
      for (int k = 0; k < 8; k++) c = ((c[0] ^ b[k]) != 1'b0) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      for (int j = 0; j < 8; j++) data_bit(b[j]);
    end
    c = ~c;
    for (int j = 0; j < 16; j++) data_bit(c[j]);
    for (int j = 0; j < 8; j++) put_bit(8'h7E >> j);
    if (e_cnt != 0) begin
      while (e_cnt < 8) begin e_acc = {1'b1, e_acc[7:1]}; e_cnt++; end
      eb[e_n] = e_acc; e_n++;
      eb[e_n] = 8'hFF; e_n++;
      e_cnt = 0;
    end
  endtask

  task automatic run(input logic m, input logic thr, input int flip, input string tag);
    int si, idle;
    logic fire;
    si = 0; idle = 0; fire = 1'b0; r_n = 0; bad_ready = 0;
    mode_56k = m;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      if (fire) si++;
      in_valid = (si < s_n) && (!thr || (cyc % 7) != 3);
      in_data  = in_valid ? sb[si] : 8'h00;
      in_last  = in_valid ? sl[si] : 1'b0;
      out_ready = !thr || (cyc % 5) > 1;
      if (cyc == flip) mode_56k = ~mode_56k;
      fire = in_valid && in_ready;
      if (in_ready && out_valid) bad_ready++;
      if (out_valid && out_ready) begin
        if (r_n < 1024) rb[r_n] = out_data;
        r_n++;
      end
      if (si >= s_n && r_n >= e_n) idle++;
      if (idle == 40) break;
    end
    in_valid = 1'b0;
    check(r_n == e_n, {tag, " R7 octet count"}, r_n, e_n);
    for (int i = 0; i < e_n && i < r_n; i++)
      check(rb[i] == eb[i], tag, rb[i], eb[i]);
    check(bad_ready == 0, "R8 ready while octet pending", bad_ready, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready, "R1 reset state", {out_valid, in_ready}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && !in_ready, "R1 idle without input", {out_valid, in_ready}, 0);

    for (int v = 0; v < 8; v++) begin
      s_n = 0; e_n = 0;
      model_frame(VEC[v][24], int'(VEC[v][23:16]), VEC[v][15:8], VEC[v][7:0]);
      run(VEC[v][24], v[0], -1, VTAG[v]);
      if (VEC[v][24]) begin
        check(rb[0] == 8'hFE, "R6 56k opening octet", rb[0], 8'hFE);
        for (int i = 0; i < r_n && i < 1024; i++)
          check(rb[i][7], "R6 top bit set", rb[i], 8'h80);
      end else
        check(rb[0] == 8'h7E, "R2 opening flag", rb[0], 8'h7E);
    end

    // R9: mode toggled mid-frame
    s_n = 0; e_n = 0;
    model_frame(1'b0, 10, 8'h3C, 8'h05);
    run(1'b0, 1'b0, 30, "R9 mode change ignored");
    s_n = 0; e_n = 0;
    model_frame(1'b1, 10, 8'hC3, 8'h07);
    run(1'b1, 1'b0, 25, "R9 mode change ignored 56k");

    // R10 and R11: back-to-back frames under back-pressure
    s_n = 0; e_n = 0;
    model_frame(1'b0, 3, 8'hF0, 8'h01);
    model_frame(1'b0, 2, 8'hFF, 8'h00);
    model_frame(1'b0, 1, 8'h7E, 8'h00);
    run(1'b0, 1'b1, -1, "R11 back-to-back R10 stall");

    // R7: a frame that closes on an octet boundary
    s_n = 0; e_n = 0;
    model_frame(1'b0, 2, 8'h00, 8'h00);
    run(1'b0, 1'b0, -1, "R7 boundary frame");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule